// File: doc/BRIEF.md
# IEEE 1284 peripheral port controller

This block is the device side of a bidirectional IEEE 1284 parallel link. In Compatibility mode it takes forward bytes from the host and hands them to an internal consumer through a valid/ready pair. When the host asks for a negotiation, the block latches the extensibility request byte and agrees to one of two reverse modes. Nibble mode sends each byte as two four-bit halves on the status lines. Byte mode drives the full byte onto the shared data bus.

A single host strobe line has three jobs. It captures forward data in Compatibility mode. It latches the request during negotiation. In the reverse modes it must never load the input latch: in Nibble mode it is held high, and in Byte mode a low pulse only acknowledges a byte. All host inputs reach the logic through a multi-stage synchronizer. Every strobe or handshake edge is found on the synchronized copy, so each reaction comes a fixed number of clocks after the line moves.

Top module: `pport_periph`

## Requirements
- R1: After reset, `phase_o` is 0 (Compatibility). `per_clk_n`, `sel_flag` and `have_data_n` are high. `per_busy`, `ack_req`, `dq_oe` and `fwd_valid` are low.
- R2: In phase 0, when `mode_act` is low, a falling `h_strobe_n` captures `dq_in` into `fwd_data`. `fwd_valid` and `per_busy` rise three clocks after the input changes, and `fwd_valid` stays high until the consumer takes the byte.
- R3: After a byte is taken with `fwd_ready`, `per_clk_n` is low for exactly ACK_CYC clocks. `per_busy` falls on the same clock that `per_clk_n` returns high.
- R4: From an idle phase 0, if `mode_act` rises while `h_busy` is low, the block enters phase 1 (negotiation) three clocks later. There it drives `per_clk_n`, `sel_flag`, `ack_req` and `have_data_n` low. If `mode_act` rises while `h_busy` is high, the phase does not change.
- R5: In phase 1, the strobe falling edge latches the request. 0x00 selects phase 3 (Nibble) and 0x01 selects phase 4 (Byte), both with `sel_flag` high. Any other value selects phase 2 (rejected), with `sel_flag` low.
- R6: In Nibble mode, a byte is taken when `rev_valid` is high and `h_busy` is low. The low half is sent first, with bit 0 on `have_data_n`, bit 1 on `sel_flag`, bit 2 on `ack_req` and bit 3 on `per_busy`. `per_clk_n` goes low one clock after the lines settle and returns high when `h_busy` rises. `h_busy` falling again starts the high half.
- R7: In Byte mode, a taken byte appears on `dq_out` with `per_clk_n` low. `per_clk_n` returns high when `h_busy` rises. The following strobe pulse ends the transfer and never raises `fwd_valid`.
- R8: `dq_oe` is high only in phase 4, and only while the synchronized `h_busy` is low, `mode_act` is high and `h_init_n` is high.
- R9: When `mode_act` falls, the block returns to phase 0. Any reverse transfer in progress is dropped, and `dq_oe` is released.
- R10: When `h_init_n` is low, the block returns to phase 0 and clears a pending forward byte: `fwd_valid` and `per_busy` go low.
- R11: A strobe falling edge outside phase 0 never raises `fwd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_strobe_n | input | 1 | Host strobe, active low |
| h_busy | input | 1 | Host busy / handshake line |
| h_init_n | input | 1 | Host initialise, active low |
| mode_act | input | 1 | Host line that selects extended (1284) operation |
| dq_in | input | DW | Data bus as seen at the pins |
| dq_out | output | DW | Data driven in Byte mode |
| dq_oe | output | 1 | Output enable for `dq_out` |
| per_clk_n | output | 1 | Peripheral clock / acknowledge, active low |
| per_busy | output | 1 | Peripheral busy, also nibble bit 3 |
| ack_req | output | 1 | Status line, also nibble bit 2 |
| sel_flag | output | 1 | Select / mode answer, also nibble bit 1 |
| have_data_n | output | 1 | Reverse data available, active low, also nibble bit 0 |
| phase_o | output | 3 | Current phase: 0 Compat, 1 Negotiate, 2 Rejected, 3 Nibble, 4 Byte |
| fwd_valid | output | 1 | A forward byte is waiting |
| fwd_data | output | DW | The forward byte |
| fwd_ready | input | 1 | Consumer takes the forward byte |
| rev_valid | input | 1 | A reverse byte is offered |
| rev_data | input | DW | The reverse byte |
| rev_ready | output | 1 | Block takes the reverse byte this clock |

## Verification
Each host line passes through two synchronizer flops before any logic sees it. As a result, a level change reaches combinational outputs such as `dq_oe` two clocks later, and a result of an edge (a phase change, a capture, a state step) appears three clocks later. The bench drives inputs one time unit after a rising edge and reads results one time unit after the third edge, or the second edge for `dq_oe`. The acknowledge width is measured clock by clock. On every falling edge, the bench also recomputes the expected `dq_oe` from its own two-clock-delayed copies of the host lines and the reported phase, and confirms that no forward byte is pending outside phase 0.

// File: rtl/pport_pkg.sv
package pport_pkg;

   typedef enum logic [2:0] {
      PH_COMPAT = 3'd0,
      PH_NEG    = 3'd1,
      PH_REJECT = 3'd2,
      PH_NIBBLE = 3'd3,
      PH_BYTE   = 3'd4
   } phase_e;

   localparam logic [7:0] REQ_NIBBLE = 8'h00;
   localparam logic [7:0] REQ_BYTE   = 8'h01;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pport_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pport_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pport_fwd.sv
module pport_fwd #(
   parameter int DW      = 8,
   parameter int ACK_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          strobe_fall,
   input  logic [DW-1:0] din,
   input  logic          fwd_ready,
   output logic          fwd_valid,
   output logic [DW-1:0] fwd_data,
   output logic          busy,
   output logic          ack_n,
   output logic          idle
);

   localparam int CW = $clog2(ACK_CYC + 1);

   if (ACK_CYC < 1) begin : g_bad_ack
      $error("pport_fwd: ACK_CYC must be at least 1");
   end

   typedef enum logic [1:0] {F_IDLE, F_HOLD, F_ACK} fst_e;

   fst_e          st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= F_IDLE;
         cnt      <= '0;
         fwd_data <= '0;
      end else if (clr) begin
         st  <= F_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            F_IDLE: if (en && strobe_fall) begin
               fwd_data <= din;
               st       <= F_HOLD;
            end
            F_HOLD: if (fwd_ready) begin
               cnt <= CW'(ACK_CYC - 1);
               st  <= F_ACK;
            end
            F_ACK: begin
               if (cnt == '0) st <= F_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   assign fwd_valid = (st == F_HOLD);
   assign busy      = (st != F_IDLE);
   assign ack_n     = (st != F_ACK);
   assign idle      = (st == F_IDLE);

   // R3: the acknowledge pulse only starts after the consumer took a byte
   p_ack_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n) |-> $past(fwd_valid && fwd_ready));

   // R11: a strobe edge while disabled leaves nothing pending
   p_no_load_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && idle && strobe_fall) |=> !fwd_valid);

endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
   import pport_pkg::*;
#(
   parameter int DW      = 8,
   parameter bit BYTE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_s,
   input  logic          act_s,
   input  logic          act_rise,
   input  logic          busy_s,
   input  logic          strobe_fall,
   input  logic [DW-1:0] din,
   input  logic          fwd_idle,
   output phase_e        phase
);

   logic byte_ok;

   if (BYTE_EN) begin : g_byte
      assign byte_ok = (din == REQ_BYTE);
   end else begin : g_no_byte
      assign byte_ok = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_COMPAT;
      end else if (!init_s) begin
         phase <= PH_COMPAT;
      end else begin
         case (phase)
            PH_COMPAT: if (act_rise && !busy_s && fwd_idle) phase <= PH_NEG;
            PH_NEG: begin
               if (!act_s)                    phase <= PH_COMPAT;
               else if (strobe_fall) begin
                  if (din == REQ_NIBBLE)      phase <= PH_NIBBLE;
                  else if (byte_ok)           phase <= PH_BYTE;
                  else                        phase <= PH_REJECT;
               end
            end
            default: if (!act_s) phase <= PH_COMPAT;
         endcase
      end
   end

   // R4: negotiation is only entered from Compatibility with the host ready
   p_neg_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_NEG && $past(phase) != PH_NEG) |->
         $past(phase == PH_COMPAT && !busy_s));

   // R5: a reverse phase is only reached through negotiation
   p_rev_from_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_NIBBLE || phase == PH_BYTE) && $past(phase) != phase) |->
         $past(phase) == PH_NEG);

   // R9 / R10: dropping the mode line or initialising returns to Compatibility
   p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((!act_s || !init_s) && phase != PH_COMPAT) |=> phase == PH_COMPAT);

endmodule

// File: rtl/pport_rev.sv
module pport_rev #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          nib_run,
   input  logic          byte_run,
   input  logic          busy_s,
   input  logic          busy_rise,
   input  logic          strobe_fall,
   input  logic          rev_valid,
   input  logic [DW-1:0] rev_data,
   output logic          rev_ready,
   output logic [DW/2-1:0] nib,
   output logic          clk_n,
   output logic [DW-1:0] hold,
   output logic          active
);

   localparam int NW = DW / 2;

   typedef enum logic [2:0] {R_IDLE, R_NSET, R_NVAL, R_NGAP, R_BVAL, R_BACK} rst_e;

   rst_e st;
   logic idx;
   logic run;

   assign run       = nib_run || byte_run;
   assign rev_ready = run && (st == R_IDLE) && rev_valid && !busy_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= R_IDLE;
         idx  <= 1'b0;
         hold <= '0;
      end else if (!run) begin
         st  <= R_IDLE;
         idx <= 1'b0;
      end else begin
         case (st)
            R_IDLE: if (rev_ready) begin
               hold <= rev_data;
               idx  <= 1'b0;
               st   <= nib_run ? R_NSET : R_BVAL;
            end
            R_NSET: st <= R_NVAL;
            R_NVAL: if (busy_rise) st <= idx ? R_IDLE : R_NGAP;
            R_NGAP: if (!busy_s) begin
               idx <= 1'b1;
               st  <= R_NSET;
            end
            R_BVAL: if (busy_rise) st <= R_BACK;
            R_BACK: if (strobe_fall) st <= R_IDLE;
            default: st <= R_IDLE;
         endcase
      end
   end

   assign nib    = idx ? hold[DW-1:NW] : hold[NW-1:0];
   assign clk_n  = !((st == R_NVAL) || (st == R_BVAL));
   assign active = (st != R_IDLE);

   // R6: the host handshake edge always releases the nibble clock
   p_nib_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == R_NVAL && busy_rise && run) |=> clk_n);

   // R6 / R7: a byte is taken once, never on two clocks in a row
   p_single_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rev_ready |=> !rev_ready);

endmodule

// File: rtl/pport_periph.sv
module pport_periph
   import pport_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_CYC     = 4,
   parameter bit BYTE_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_strobe_n,
   input  logic          h_busy,
   input  logic          h_init_n,
   input  logic          mode_act,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe,
   output logic          per_clk_n,
   output logic          per_busy,
   output logic          ack_req,
   output logic          sel_flag,
   output logic          have_data_n,
   output logic [2:0]    phase_o,
   output logic          fwd_valid,
   output logic [DW-1:0] fwd_data,
   input  logic          fwd_ready,
   input  logic          rev_valid,
   input  logic [DW-1:0] rev_data,
   output logic          rev_ready
);

   localparam int HW = DW + 4;
   localparam logic [HW-1:0] H_IDLE = {1'b0, 1'b1, 1'b1, 1'b1, {DW{1'b0}}};

   if (DW != 8) begin : g_bad_dw
      $error("pport_periph: the link carries 8-bit data, DW must be 8");
   end

   logic [HW-1:0] h_raw, h_syn;
   logic          act_s, init_s, busy_s, strobe_s;
   logic [DW-1:0] dq_s;
   logic          strobe_q, busy_q, act_q;
   logic          strobe_fall, busy_rise, act_rise;

   assign h_raw = {mode_act, h_init_n, h_busy, h_strobe_n, dq_in};

   pport_sync #(.W(HW), .STAGES(SYNC_STAGES), .RST_VAL(H_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (h_raw),
      .q     (h_syn)
   );

   assign {act_s, init_s, busy_s, strobe_s, dq_s} = h_syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b1;
         busy_q   <= 1'b1;
         act_q    <= 1'b0;
      end else begin
         strobe_q <= strobe_s;
         busy_q   <= busy_s;
         act_q    <= act_s;
      end
   end

   assign strobe_fall = strobe_q && !strobe_s;
   assign busy_rise   = !busy_q && busy_s;
   assign act_rise    = !act_q && act_s;

   phase_e phase;
   logic   fwd_busy, fwd_ack_n, fwd_idle;

   pport_ctl #(.DW(DW), .BYTE_EN(BYTE_EN)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_s      (init_s),
      .act_s       (act_s),
      .act_rise    (act_rise),
      .busy_s      (busy_s),
      .strobe_fall (strobe_fall),
      .din         (dq_s),
      .fwd_idle    (fwd_idle),
      .phase       (phase)
   );

   pport_fwd #(.DW(DW), .ACK_CYC(ACK_CYC)) u_fwd (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (!init_s),
      .en          ((phase == PH_COMPAT) && !act_s),
      .strobe_fall (strobe_fall),
      .din         (dq_s),
      .fwd_ready   (fwd_ready),
      .fwd_valid   (fwd_valid),
      .fwd_data    (fwd_data),
      .busy        (fwd_busy),
      .ack_n       (fwd_ack_n),
      .idle        (fwd_idle)
   );

   logic            nib_run, byte_run;
   logic [DW/2-1:0] rv_nib;
   logic            rv_clk_n, rv_active;
   logic [DW-1:0]   rv_hold;

   assign nib_run  = (phase == PH_NIBBLE);
   assign byte_run = (phase == PH_BYTE);

   pport_rev #(.DW(DW)) u_rev (
      .clk         (clk),
      .rst_n       (rst_n),
      .nib_run     (nib_run),
      .byte_run    (byte_run),
      .busy_s      (busy_s),
      .busy_rise   (busy_rise),
      .strobe_fall (strobe_fall),
      .rev_valid   (rev_valid),
      .rev_data    (rev_data),
      .rev_ready   (rev_ready),
      .nib         (rv_nib),
      .clk_n       (rv_clk_n),
      .hold        (rv_hold),
      .active      (rv_active)
   );

   always_comb begin
      per_clk_n   = 1'b1;
      per_busy    = 1'b0;
      ack_req     = 1'b0;
      sel_flag    = 1'b1;
      have_data_n = 1'b1;
      case (phase)
         PH_COMPAT: begin
            per_clk_n = fwd_ack_n;
            per_busy  = fwd_busy;
         end
         PH_NEG: begin
            per_clk_n   = 1'b0;
            sel_flag    = 1'b0;
            ack_req     = 1'b0;
            have_data_n = 1'b0;
         end
         PH_REJECT: sel_flag = 1'b0;
         PH_NIBBLE: begin
            per_clk_n = rv_clk_n;
            if (rv_active) begin
               have_data_n = rv_nib[0];
               sel_flag    = rv_nib[1];
               ack_req     = rv_nib[2];
               per_busy    = rv_nib[3];
            end else begin
               have_data_n = !rev_valid;
            end
         end
         PH_BYTE: begin
            per_clk_n   = rv_clk_n;
            per_busy    = rv_active;
            have_data_n = !rev_valid;
         end
         default: ;
      endcase
   end

   assign dq_out  = rv_hold;
   assign dq_oe   = byte_run && !busy_s && act_s && init_s;
   assign phase_o = phase;

   // R11: no forward byte may be pending outside Compatibility
   p_fwd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_COMPAT) |-> !fwd_valid);

endmodule

// File: tb/pport_periph_bench.sv
`timescale 1ns/100ps
module pport_periph_bench;

   localparam int DW  = 8;
   localparam int ACK = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_strobe_n = 1'b1, h_busy = 1'b1, h_init_n = 1'b1, mode_act = 1'b0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe, per_clk_n, per_busy, ack_req, sel_flag, have_data_n;
   logic [2:0]    phase_o;
   logic          fwd_valid;
   logic [DW-1:0] fwd_data;
   logic          fwd_ready = 1'b0;
   logic          rev_valid = 1'b0;
   logic [DW-1:0] rev_data = '0;
   logic          rev_ready;

   int checks = 0;
   int fails  = 0;
   int pops   = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pport_periph #(.DW(DW), .ACK_CYC(ACK)) u_pport_periph (
      .clk(clk), .rst_n(rst_n), .h_strobe_n(h_strobe_n), .h_busy(h_busy),
      .h_init_n(h_init_n), .mode_act(mode_act), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .per_clk_n(per_clk_n), .per_busy(per_busy),
      .ack_req(ack_req), .sel_flag(sel_flag), .have_data_n(have_data_n),
      .phase_o(phase_o), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
      .fwd_ready(fwd_ready), .rev_valid(rev_valid), .rev_data(rev_data),
      .rev_ready(rev_ready)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // reference view of the host lines as the block sees them, two clocks late
   logic bq1 = 1'b1, bq2 = 1'b1, aq1 = 1'b0, aq2 = 1'b0, iq1 = 1'b1, iq2 = 1'b1;
   always @(posedge clk) begin
      bq1 <= h_busy;   bq2 <= bq1;
      aq1 <= mode_act; aq2 <= aq1;
      iq1 <= h_init_n; iq2 <= iq1;
   end

   // per-clock model comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 oe model", dq_oe, (phase_o == 3'd4) && !bq2 && aq2 && iq2);
         if (phase_o != 3'd0) chk("R11 no fwd outside compat", fwd_valid, 1'b0);
         if (rev_valid && rev_ready) pops++;
      end
   end

   task automatic summary;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(3);
      // R1 reset state
      chk("R1 phase", phase_o, 3'd0);
      chk("R1 per_clk_n", per_clk_n, 1'b1);
      chk("R1 per_busy", per_busy, 1'b0);
      chk("R1 sel_flag", sel_flag, 1'b1);
      chk("R1 ack_req", ack_req, 1'b0);
      chk("R1 have_data_n", have_data_n, 1'b1);
      chk("R1 dq_oe", dq_oe, 1'b0);
      chk("R1 fwd_valid", fwd_valid, 1'b0);

      // R2 forward capture, consumer not ready
      dq_in = 8'hA5; h_strobe_n = 1'b0;
      edges(2);
      chk("R2 not before third edge", fwd_valid, 1'b0);
      edges(1);
      chk("R2 fwd_valid", fwd_valid, 1'b1);
      chk("R2 fwd_data", fwd_data, 8'hA5);
      chk("R2 per_busy", per_busy, 1'b1);
      h_strobe_n = 1'b1;
      edges(3);
      chk("R2 held until taken", fwd_valid, 1'b1);

      // R3 acknowledge width
      fwd_ready = 1'b1;
      edges(1);
      fwd_ready = 1'b0;
      chk("R3 taken", fwd_valid, 1'b0);
      begin
         int low = 0;
         while (per_clk_n == 1'b0 && low < 20) begin
            low++;
            edges(1);
         end
         chk("R3 ack width", low, ACK);
         chk("R3 busy released", per_busy, 1'b0);
      end

      // R2 second pattern with ready held
      fwd_ready = 1'b1; dq_in = 8'h3C; h_strobe_n = 1'b0;
      edges(3);
      chk("R2 second byte valid", fwd_valid, 1'b1);
      chk("R2 second byte data", fwd_data, 8'h3C);
      h_strobe_n = 1'b1;
      edges(ACK + 1);
      chk("R3 second busy released", per_busy, 1'b0);
      chk("R3 second clk high", per_clk_n, 1'b1);
      fwd_ready = 1'b0;

      // R10 init clears a pending byte
      dq_in = 8'h77; h_strobe_n = 1'b0;
      edges(3);
      chk("R10 pending", fwd_valid, 1'b1);
      h_strobe_n = 1'b1; h_init_n = 1'b0;
      edges(3);
      chk("R10 cleared", fwd_valid, 1'b0);
      chk("R10 busy low", per_busy, 1'b0);
      h_init_n = 1'b1;
      edges(3);

      // R4 no negotiation while host busy high
      mode_act = 1'b1;
      edges(3);
      chk("R4 ignored with busy high", phase_o, 3'd0);
      mode_act = 1'b0;
      edges(3);

      // R4 / R5 nibble negotiation
      h_busy = 1'b0; mode_act = 1'b1;
      edges(3);
      chk("R4 phase neg", phase_o, 3'd1);
      chk("R4 lines low", {per_clk_n, sel_flag, ack_req, have_data_n}, 4'b0000);
      dq_in = 8'h00; h_strobe_n = 1'b0;
      edges(3);
      chk("R5 nibble phase", phase_o, 3'd3);
      chk("R5 nibble accepted", sel_flag, 1'b1);
      h_strobe_n = 1'b1; h_busy = 1'b1;
      edges(3);

      // R11 strobe in nibble mode is ignored
      dq_in = 8'hEE; h_strobe_n = 1'b0;
      edges(3);
      chk("R11 no capture", fwd_valid, 1'b0);
      chk("R11 still nibble", phase_o, 3'd3);
      h_strobe_n = 1'b1;
      edges(3);

      // R6 nibble transfer of 0x9C
      rev_valid = 1'b1; rev_data = 8'h9C; h_busy = 1'b0;
      edges(3);
      rev_valid = 1'b0;
      chk("R6 low nibble lines", {per_busy, ack_req, sel_flag, have_data_n}, 4'hC);
      chk("R6 clk high at setup", per_clk_n, 1'b1);
      edges(1);
      chk("R6 clk low", per_clk_n, 1'b0);
      h_busy = 1'b1;
      edges(3);
      chk("R6 clk released", per_clk_n, 1'b1);
      h_busy = 1'b0;
      edges(3);
      chk("R6 high nibble lines", {per_busy, ack_req, sel_flag, have_data_n}, 4'h9);
      edges(1);
      chk("R6 clk low second", per_clk_n, 1'b0);
      h_busy = 1'b1;
      edges(3);
      chk("R6 back to idle clk", per_clk_n, 1'b1);
      chk("R6 idle no data", have_data_n, 1'b1);
      chk("R6 one byte taken", pops, 1);

      // R9 abort a nibble transfer
      rev_valid = 1'b1; rev_data = 8'h5A; h_busy = 1'b0;
      edges(4);
      rev_valid = 1'b0;
      chk("R9 mid transfer", per_clk_n, 1'b0);
      mode_act = 1'b0;
      edges(4);
      chk("R9 phase compat", phase_o, 3'd0);
      chk("R9 clk released", per_clk_n, 1'b1);
      chk("R9 select restored", sel_flag, 1'b1);
      h_busy = 1'b1;
      edges(3);

      // R5 / R7 / R8 byte mode
      h_busy = 1'b0; mode_act = 1'b1;
      edges(3);
      chk("R4 phase neg again", phase_o, 3'd1);
      dq_in = 8'h01; h_strobe_n = 1'b0;
      edges(3);
      chk("R5 byte phase", phase_o, 3'd4);
      chk("R8 oe while busy low", dq_oe, 1'b1);
      h_strobe_n = 1'b1; h_busy = 1'b1;
      edges(3);
      chk("R8 oe off while busy high", dq_oe, 1'b0);
      rev_valid = 1'b1; rev_data = 8'hE1; h_busy = 1'b0;
      edges(3);
      rev_valid = 1'b0;
      chk("R7 clk low", per_clk_n, 1'b0);
      chk("R7 dq_out", dq_out, 8'hE1);
      chk("R7 oe", dq_oe, 1'b1);
      h_busy = 1'b1;
      edges(3);
      chk("R7 clk released", per_clk_n, 1'b1);
      chk("R8 oe dropped", dq_oe, 1'b0);
      dq_in = 8'h42; h_strobe_n = 1'b0;
      edges(3);
      chk("R7 ack no capture", fwd_valid, 1'b0);
      chk("R7 transfer ended", per_busy, 1'b0);
      h_strobe_n = 1'b1;
      edges(3);

      // R9 oe released on mode drop
      h_busy = 1'b0;
      edges(3);
      chk("R8 oe idle busy low", dq_oe, 1'b1);
      mode_act = 1'b0;
      edges(3);
      chk("R9 oe released", dq_oe, 1'b0);
      chk("R9 phase compat", phase_o, 3'd0);
      h_busy = 1'b1;
      edges(3);

      // R5 rejected request
      h_busy = 1'b0; mode_act = 1'b1;
      edges(3);
      dq_in = 8'h10; h_strobe_n = 1'b0;
      edges(3);
      chk("R5 reject phase", phase_o, 3'd2);
      chk("R5 reject flag", sel_flag, 1'b0);
      h_strobe_n = 1'b1; mode_act = 1'b0; h_busy = 1'b1;
      edges(4);
      chk("R9 reject exit", phase_o, 3'd0);

      summary();
   end

endmodule